// File: doc/BRIEF.md
# Toggle-Capable DAC Code Register Bank

This block holds the digital state behind a 32-channel voltage-output converter. Each channel owns two data registers, a primary (A) and an alternate (B), plus an output code register that feeds the converter core. A parallel write port selects a register kind with two select bits, a channel with a 5-bit address, and carries a 14-bit data word. One address under the control select reaches a small control register. That register switches an alternating mode on or off for each bank of eight channels.

Nothing reaches the outputs until a load strobe arrives. The strobe comes in as an asynchronous level, is synchronised to the core clock and is turned into a single-cycle update pulse on its rising edge. In a bank with alternating mode off, every update copies A to the output. In a bank with it on, successive updates give A, B, A, B and so on, so the output forms a square wave at half the strobe rate. Whenever a bank's enable changes, its sequence restarts, so the next update selects A. The intended setup is: enable the banks, load A, load B, then pulse the strobe.

Top module: `dac_toggle_bank`

## Requirements
- R1: After synchronous active-low reset, every output code, every A and B register, every phase flag and all bank enables are zero.
- R2: A write with select 2'b11 stores the data word in the A register of the addressed channel. The output does not change until the next update.
- R3: A write with select 2'b00 to address 5'b01100 loads the bank enables from data bits 5..2. Bit 2 covers channels 0-7 and bit 5 covers channels 24-31. A select-2'b00 write to any other address has no effect.
- R4: A write with select 2'b10 stores into the addressed channel's B register only while that channel's bank is enabled. Otherwise it is dropped and B keeps its old value.
- R5: On every update, a channel whose bank is not enabled loads its A register into its output.
- R6: In an enabled bank, the first update after enabling loads A and the following updates alternate B, A, B and so on.
- R7: The first update after a bank is disabled loads A, as do all later ones while the bank stays disabled.
- R8: Each rising edge of the strobe input causes exactly one update, however long the strobe stays high. Outputs hold their value between updates.
- R9: Any change to a bank's enable clears the phase flags of that bank, so re-enabling a bank in the middle of a sequence restarts it at A.
- R10: A write with select 2'b01 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Register kind: 11 = A, 10 = B, 00 = control, 01 = none |
| wr_addr | input | 5 | Channel index, or control address under select 00 |
| wr_data | input | 14 | Write data word |
| ldac_in | input | 1 | Asynchronous load strobe; a rising edge triggers one update |
| codes_out | output | 448 | Output codes; channel n occupies bits n*14 +: 14 |

## Verification
Directed steps first walk a single bank through an unchanged output after an A write, a B write that is dropped, enabling, an A/B/A sequence, disabling and a re-enable in mid-sequence. This separates the phase-restart behaviour from plain alternation. The strobe is then held high for many cycles to tell a single edge-triggered update from a level-sensitive one. Random mixes of A, B, control, unused-select and wrong-address writes with strobes follow, spread across all four banks. After each strobe all 32 outputs are compared with a bench model, which exposes errors in bank mapping, B gating and phase tracking that a single bank would hide.

// File: rtl/dac_toggle_pkg.sv
package dac_toggle_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_NONE = 2'b01,
      SEL_B    = 2'b10,
      SEL_A    = 2'b11
   } reg_sel_e;
endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ldac_in,
   output logic strobe
);
   logic synced;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = ldac_in;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], ldac_in} >> 0;
         end
         assign synced = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   assign strobe = synced & ~prev_q;

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
   import dac_toggle_pkg::*;
#(
   parameter int                ADDR_W     = 5,
   parameter int                DATA_W     = 14,
   parameter int                NUM_GROUPS = 4,
   parameter int                EN_LSB     = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 5'b01100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [NUM_GROUPS-1:0] grp_en,
   output logic [NUM_GROUPS-1:0] grp_chg
);
   logic                  ctrl_hit;
   logic [NUM_GROUPS-1:0] new_en;

   assign ctrl_hit = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && (wr_addr == CTRL_ADDR);
   assign new_en   = wr_data[EN_LSB +: NUM_GROUPS];
   assign grp_chg  = ctrl_hit ? (new_en ^ grp_en) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)        grp_en <= '0;
      else if (ctrl_hit) grp_en <= new_en;
   end

   assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_hit |=> $stable(grp_en));
   assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> grp_en == $past(wr_data[EN_LSB +: NUM_GROUPS]));
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              grp_en,
   input  logic              grp_chg,
   input  logic              strobe,
   output logic [DATA_W-1:0] code_out
);
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic              phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q      <= '0;
         b_q      <= '0;
         phase_q  <= 1'b0;
         code_out <= '0;
      end else begin
         if (wr_a)           a_q <= wr_data;
         if (wr_b && grp_en) b_q <= wr_data;
         if (strobe)         code_out <= (grp_en && phase_q) ? b_q : a_q;
         if (grp_chg)                phase_q <= 1'b0;
         else if (strobe && grp_en)  phase_q <= ~phase_q;
      end
   end

   assert_b_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_b && grp_en) |=> $stable(b_q));
   assert_plain_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !grp_en) |=> code_out == $past(a_q));
   assert_phase_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && grp_en && !phase_q) |=> code_out == $past(a_q));
   assert_phase_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && grp_en && phase_q) |=> code_out == $past(b_q));
   assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(code_out));
   assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grp_chg |=> !phase_q);
endmodule

// File: rtl/dac_toggle_bank.sv
module dac_toggle_bank
   import dac_toggle_pkg::*;
#(
   parameter int                NUM_CH      = 32,
   parameter int                GROUP_SIZE  = 8,
   parameter int                DATA_W      = 14,
   parameter int                ADDR_W      = 5,
   parameter int                EN_LSB      = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 5'b01100,
   parameter int                SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     ldac_in,
   output logic [NUM_CH*DATA_W-1:0] codes_out
);
   localparam int NUM_GROUPS = NUM_CH / GROUP_SIZE;

   if (NUM_CH % GROUP_SIZE != 0) begin : g_bad_groups
      $error("NUM_CH must be a multiple of GROUP_SIZE");
   end
   if (NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_CH");
   end
   if (EN_LSB + NUM_GROUPS > DATA_W) begin : g_bad_ctrl
      $error("enable field does not fit in the data word");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 or at least 2");
   end

   logic                  strobe;
   logic [NUM_GROUPS-1:0] grp_en;
   logic [NUM_GROUPS-1:0] grp_chg;
   logic                  sel_a;
   logic                  sel_b;

   assign sel_a = wr_en && (reg_sel_e'(wr_sel) == SEL_A);
   assign sel_b = wr_en && (reg_sel_e'(wr_sel) == SEL_B);

   dac_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .ldac_in (ldac_in),
      .strobe  (strobe)
   );

   dac_ctrl_reg #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_GROUPS (NUM_GROUPS),
      .EN_LSB     (EN_LSB),
      .CTRL_ADDR  (CTRL_ADDR)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .grp_en  (grp_en),
      .grp_chg (grp_chg)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int GRP = ch / GROUP_SIZE;
      logic hit;
      assign hit = (wr_addr == ADDR_W'(ch));
      dac_channel #(.DATA_W(DATA_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_a     (sel_a && hit),
         .wr_b     (sel_b && hit),
         .wr_data  (wr_data),
         .grp_en   (grp_en[GRP]),
         .grp_chg  (grp_chg[GRP]),
         .strobe   (strobe),
         .code_out (codes_out[ch*DATA_W +: DATA_W])
      );
   end

   assert_reset_out_R1: assert property (@(posedge clk)
      !rst_n |=> (codes_out == '0 && grp_en == '0));
endmodule

// File: tb/test_dac_toggle_bank.sv
`timescale 1ns/1ps
module test_dac_toggle_bank;
   localparam int NCH = 32;
   localparam int DW  = 14;
   localparam int GS  = 8;
   localparam int NG  = NCH / GS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_sel = 2'b01;
   logic [4:0]      wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            ldac_in = 1'b0;
   logic [NCH*DW-1:0] codes_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [DW-1:0] ma [NCH];
   logic [DW-1:0] mb [NCH];
   logic [DW-1:0] mo [NCH];
   bit            mph [NCH];
   bit            men [NG];

   always #2.5 clk = ~clk;

   dac_toggle_bank i_dac_toggle_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .ldac_in(ldac_in),
      .codes_out(codes_out)
   );

   function automatic logic [DW-1:0] upd_code(int ch);
      int g = ch / GS;
      if (men[g] && mph[ch]) return mb[ch];
      return ma[ch];
   endfunction

   task automatic check_all(string tag);
      for (int ch = 0; ch < NCH; ch++) begin
         n_cmp++;
         if (codes_out[ch*DW +: DW] !== mo[ch]) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual %h expected %h", tag, ch,
                     codes_out[ch*DW +: DW], mo[ch]);
         end
      end
   endtask

   task automatic do_write(logic [1:0] sel, logic [4:0] addr, logic [DW-1:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'b01;
      case (sel)
         2'b11: ma[addr] = data;
         2'b10: if (men[addr / GS]) mb[addr] = data;
         2'b00: if (addr == 5'b01100) begin
            for (int g = 0; g < NG; g++) begin
               if (men[g] != data[2+g]) begin
                  for (int c = g*GS; c < (g+1)*GS; c++) mph[c] = 1'b0;
               end
               men[g] = data[2+g];
            end
         end
         default: ;
      endcase
   endtask

   task automatic pulse(int high_cycles);
      @(negedge clk);
      ldac_in = 1'b1;
      repeat (high_cycles) @(negedge clk);
      ldac_in = 1'b0;
      repeat (5) @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
         mo[ch] = upd_code(ch);
         if (men[ch / GS]) mph[ch] = ~mph[ch];
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int r;
      void'($urandom(32'd2024));
      for (int c = 0; c < NCH; c++) begin ma[c] = '0; mb[c] = '0; mo[c] = '0; mph[c] = 0; end
      for (int g = 0; g < NG; g++) men[g] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R2: A write alone does not reach output
      do_write(2'b11, 5'd3, 14'h1111);
      do_write(2'b11, 5'd5, 14'h2222);
      repeat (3) @(negedge clk);
      check_all("R2 no update before strobe");
      // R4: B write while bank disabled is dropped
      do_write(2'b10, 5'd3, 14'h3AAA);
      // R5: plain load
      pulse(3);
      check_all("R5 plain load");
      // R3: wrong control address ignored, R10: unused select ignored
      do_write(2'b00, 5'd13, 14'h003C);
      do_write(2'b01, 5'd3, 14'h0F0F);
      pulse(3);
      check_all("R3 R10 ignored writes");
      // R3 enable bank 0, R6 sequence
      do_write(2'b00, 5'b01100, 14'h0004);
      do_write(2'b10, 5'd5, 14'h0555);
      pulse(3); check_all("R6 first is A");
      pulse(3); check_all("R6 second is B R4 dropped B");
      pulse(3); check_all("R6 third is A");
      pulse(3); check_all("R6 fourth is B");
      // R9: disable/enable mid-sequence, phase restart
      pulse(3);
      do_write(2'b00, 5'b01100, 14'h0000);
      do_write(2'b00, 5'b01100, 14'h0004);
      pulse(3); check_all("R9 restart at A");
      pulse(3); check_all("R9 then B");
      // R7: disable returns to A
      do_write(2'b00, 5'b01100, 14'h0000);
      pulse(3); check_all("R7 first after disable");
      pulse(3); check_all("R7 stays A");
      // R8: long-held strobe gives a single update
      do_write(2'b00, 5'b01100, 14'h003C);
      for (int c = 0; c < NCH; c++) begin
         do_write(2'b11, 5'(c), 14'(c * 37 + 1));
         do_write(2'b10, 5'(c), 14'(c * 91 + 7));
      end
      pulse(40); check_all("R8 long strobe one update");
      pulse(40); check_all("R8 long strobe second update");
      repeat (20) @(negedge clk);
      check_all("R8 hold between strobes");

      // random mix
      for (int i = 0; i < 600; i++) begin
         r = int'($urandom_range(0, 9));
         case (r)
            0, 1, 2: do_write(2'b11, 5'($urandom_range(0, 31)), 14'($urandom));
            3, 4:    do_write(2'b10, 5'($urandom_range(0, 31)), 14'($urandom));
            5:       do_write(2'b00, 5'b01100, 14'($urandom));
            6:       do_write(2'b00, 5'($urandom_range(0, 31)), 14'($urandom));
            7:       do_write(2'b01, 5'($urandom_range(0, 31)), 14'($urandom));
            default: begin
               pulse(int'($urandom_range(1, 6)));
               check_all("R5 R6 R7 R9 random");
            end
         endcase
      end
      pulse(2);
      check_all("R4 R10 random final");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule